// File: doc/BRIEF.md
# Dual Linear Aperture Address Mapper

This block sits between the host bus and the memory controller of a graphics device. The host sees two linear memory windows of equal size. Each host access names a window and an offset inside it. The block turns that access into a memory controller address, byte-reverses the data when that window is set to big-endian, and tags the access as frame buffer space or as image space for the accelerated graphics port. An offset that maps to nothing is refused with an error flag, and no request is sent for it.

A small configuration register window is read and written over a simple register bus with byte enables. It reports the two window base addresses, the base and size of the register window, and the fixed window size. It also holds the writable controls: the memory size, the start of the port image, the per-window byte-order bits, and a mode bit. The mode bit either makes both windows mirror the same memory or stacks window 1 above window 0, which gives one region of twice the size.

Top module: `aper_xlate`

## Requirements
- R1: After reset, reads return these values: 0x02000000 at 0x108 (window size), 0 at 0x130 (host path control), 0x01000000 at 0x0F8 (memory size), 0x01800000 at 0x118 (port image offset) and 0 at 0x11C (byte-order control). Every register read returns its data in the cycle after `cfg_rd`, with `cfg_rvalid` high.
- R2: When bit 23 of 0x130 is 0, an accepted access in either window produces `mc_addr = fb_start + offset`.
- R3: When bit 23 of 0x130 is 1, window 1 produces `mc_addr = fb_start + 0x02000000 + offset`, and window 0 still produces `fb_start + offset`.
- R4: An accepted access with offset >= the port image offset (0x118) and offset < the window size raises `mc_agp`. An access with offset < the memory size (0x0F8) leaves `mc_agp` low.
- R5: An offset >= the window size, or an offset with memory size <= offset < port image offset, raises `h_err` and leaves `mc_req` low.
- R6: Bit 0 of 0x11C selects byte reversal for window 0, and bit 1 selects it for window 1. A window with its bit set sends `mc_wdata` as the fully byte-reversed `h_wdata`. A window with its bit clear passes the data through unchanged.
- R7: Read data on `mc_rdata` appears on `h_rdata` one cycle later with `h_rvalid` high. It is byte-reversed when the byte-order bit of the window named by `mc_rsel` is set.
- R8: Offsets 0x100 and 0x104 return `bar_ap0` and `bar_ap1` with bits 3:0 cleared. Offset 0x10C returns `bar_reg` with bits 3:0 cleared, and offset 0x110 returns the register window size, 0x4000.
- R9: On a read, byte lanes whose `cfg_be` bit is clear return zero. On a write, only the lanes whose `cfg_be` bit is set are changed. Bit 23 of 0x130 lies in lane 2.
- R10: Writes to the read-only offsets 0x100 to 0x110 have no effect. In 0x130, every bit except bit 23 reads as zero.
- R11: A configuration write and a host access in the same cycle: the access uses the settings that were in force before the write.
- R12: `mc_req` or `h_err` follows an `h_req` by exactly one cycle. With no `h_req`, both stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fb_start | input | 32 | Frame buffer start in memory controller space |
| bar_ap0 | input | 32 | Base address register of window 0 |
| bar_ap1 | input | 32 | Base address register of window 1 |
| bar_reg | input | 32 | Base address register of the register window |
| h_req | input | 1 | Host window access strobe |
| h_sel | input | 1 | Window select (0 or 1) |
| h_we | input | 1 | Host access is a write |
| h_off | input | 32 | Offset within the window |
| h_wdata | input | 32 | Host write data |
| mc_req | output | 1 | Request to the memory controller |
| mc_we | output | 1 | Request is a write |
| mc_addr | output | 32 | Memory controller address |
| mc_wdata | output | 32 | Write data after byte-order handling |
| mc_agp | output | 1 | Access falls in port image space |
| h_err | output | 1 | Access refused |
| mc_rvalid | input | 1 | Read data valid from the memory controller |
| mc_rsel | input | 1 | Window that the read data belongs to |
| mc_rdata | input | 32 | Read data from the memory controller |
| h_rvalid | output | 1 | Read data valid to the host |
| h_rdata | output | 32 | Read data after byte-order handling |
| cfg_rd | input | 1 | Register read strobe |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte offset |
| cfg_be | input | 4 | Byte lane enables |
| cfg_wdata | input | 32 | Register write data |
| cfg_rvalid | output | 1 | Register read data valid |
| cfg_rdata | output | 32 | Register read data |

## Verification
Two functions can fall in the same cycle: a configuration write that changes the mode bit or a byte-order bit, and a host access that depends on that setting. The bench provokes this by first stacking the windows. It then asserts `h_req` on window 1 together with a write that clears the mode bit. The returned address must still carry the stacked offset. A second access right after it must show the mirrored address. The byte-order bit is handled the same way, and the bench judges it by the `mc_wdata` of the access issued alongside the write.

// File: rtl/aper_pkg.sv
package aper_pkg;

    localparam logic [11:0] OFS_MEMSIZE = 12'h0F8;
    localparam logic [11:0] OFS_BASE0   = 12'h100;
    localparam logic [11:0] OFS_BASE1   = 12'h104;
    localparam logic [11:0] OFS_WINSIZE = 12'h108;
    localparam logic [11:0] OFS_REGBASE = 12'h10C;
    localparam logic [11:0] OFS_REGSIZE = 12'h110;
    localparam logic [11:0] OFS_AGPOFS  = 12'h118;
    localparam logic [11:0] OFS_ORDER   = 12'h11C;
    localparam logic [11:0] OFS_PATH    = 12'h130;
    localparam int          PATH_MODE_BIT = 23;

    function automatic logic [31:0] lane_mask(input logic [3:0] be);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{be[i]}};
        return m;
    endfunction

    function automatic logic [31:0] lane_merge(input logic [31:0] old_v,
                                               input logic [31:0] new_v,
                                               input logic [3:0]  be);
        logic [31:0] m;
        m = lane_mask(be);
        return (old_v & ~m) | (new_v & m);
    endfunction

endpackage

// File: rtl/aper_swap.sv
module aper_swap #(
    parameter int LANES = 4
) (
    input  logic [LANES*8-1:0] din,
    input  logic               en,
    output logic [LANES*8-1:0] dout
);
    logic [LANES*8-1:0] rev;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign rev[i*8 +: 8] = din[(LANES-1-i)*8 +: 8];
    end

    assign dout = en ? rev : din;
endmodule

// File: rtl/aper_decode.sv
module aper_decode #(
    parameter int          IDX       = 0,
    parameter int          AW        = 32,
    parameter logic [31:0] APER_SIZE = 32'h0200_0000
) (
    input  logic [AW-1:0] off,
    input  logic [AW-1:0] fb_start,
    input  logic          stack,
    input  logic [AW-1:0] memsize,
    input  logic [AW-1:0] agp_off,
    output logic [AW-1:0] addr,
    output logic          err,
    output logic          agp
);
    localparam logic [AW-1:0] SIZE_W = AW'(APER_SIZE);

    logic out_of_win;
    logic in_gap;

    always_comb begin
        out_of_win = (off >= SIZE_W);
        in_gap     = (off >= memsize) && (off < agp_off);
        err        = out_of_win || in_gap;
        agp        = !err && (off >= agp_off);
        if (IDX == 1) begin
            addr = fb_start + off + (stack ? SIZE_W : '0);
        end else begin
            addr = fb_start + off;
        end
    end
endmodule

// File: rtl/aper_cfg.sv
module aper_cfg
    import aper_pkg::*;
#(
    parameter logic [31:0] APER_SIZE = 32'h0200_0000,
    parameter logic [31:0] MEM_RST   = 32'h0100_0000,
    parameter logic [31:0] AGP_RST   = 32'h0180_0000,
    parameter logic [31:0] REG_WIN   = 32'h0000_4000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd,
    input  logic        wr,
    input  logic [11:0] addr,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    input  logic [31:0] bar_ap0,
    input  logic [31:0] bar_ap1,
    input  logic [31:0] bar_reg,
    output logic        rvalid,
    output logic [31:0] rdata,
    output logic        stack,
    output logic [1:0]  order,
    output logic [31:0] memsize,
    output logic [31:0] agp_off
);
    localparam logic [31:0] SIZE_FIELD = APER_SIZE & 32'h03FF_FFFF & ~32'h01FF_FFFF;

    typedef struct packed {
        logic        stack;
        logic [1:0]  order;
        logic [31:0] memsize;
        logic [31:0] agp_off;
        logic        rvalid;
        logic [31:0] rdata;
    } cfg_t;

    cfg_t s_d, s_q;
    logic [31:0] word;
    logic [31:0] path_word;
    logic [31:0] merged;

    always_comb begin
        path_word = '0;
        path_word[PATH_MODE_BIT] = s_q.stack;
        case (addr)
            OFS_MEMSIZE: word = s_q.memsize;
            OFS_BASE0:   word = bar_ap0 & 32'hFFFF_FFF0;
            OFS_BASE1:   word = bar_ap1 & 32'hFFFF_FFF0;
            OFS_WINSIZE: word = SIZE_FIELD;
            OFS_REGBASE: word = bar_reg & 32'hFFFF_FFF0;
            OFS_REGSIZE: word = REG_WIN;
            OFS_AGPOFS:  word = s_q.agp_off;
            OFS_ORDER:   word = {30'b0, s_q.order};
            OFS_PATH:    word = path_word;
            default:     word = '0;
        endcase
        merged = lane_merge(word, wdata, be);

        s_d        = s_q;
        s_d.rvalid = rd;
        s_d.rdata  = rd ? (word & lane_mask(be)) : '0;
        if (wr) begin
            case (addr)
                OFS_MEMSIZE: s_d.memsize = merged;
                OFS_AGPOFS:  s_d.agp_off = merged;
                OFS_ORDER:   s_d.order   = merged[1:0];
                OFS_PATH:    s_d.stack   = merged[PATH_MODE_BIT];
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.stack   <= 1'b0;
            s_q.order   <= 2'b00;
            s_q.memsize <= MEM_RST;
            s_q.agp_off <= AGP_RST;
            s_q.rvalid  <= 1'b0;
            s_q.rdata   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rvalid  = s_q.rvalid;
    assign rdata   = s_q.rdata;
    assign stack   = s_q.stack;
    assign order   = s_q.order;
    assign memsize = s_q.memsize;
    assign agp_off = s_q.agp_off;
endmodule

// File: rtl/aper_xlate.sv
module aper_xlate #(
    parameter logic [31:0] APER_SIZE = 32'h0200_0000,
    parameter logic [31:0] MEM_RST   = 32'h0100_0000,
    parameter logic [31:0] AGP_RST   = 32'h0180_0000,
    parameter logic [31:0] REG_WIN   = 32'h0000_4000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] fb_start,
    input  logic [31:0] bar_ap0,
    input  logic [31:0] bar_ap1,
    input  logic [31:0] bar_reg,
    input  logic        h_req,
    input  logic        h_sel,
    input  logic        h_we,
    input  logic [31:0] h_off,
    input  logic [31:0] h_wdata,
    output logic        mc_req,
    output logic        mc_we,
    output logic [31:0] mc_addr,
    output logic [31:0] mc_wdata,
    output logic        mc_agp,
    output logic        h_err,
    input  logic        mc_rvalid,
    input  logic        mc_rsel,
    input  logic [31:0] mc_rdata,
    output logic        h_rvalid,
    output logic [31:0] h_rdata,
    input  logic        cfg_rd,
    input  logic        cfg_wr,
    input  logic [11:0] cfg_addr,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    output logic        cfg_rvalid,
    output logic [31:0] cfg_rdata
);
    localparam int NAP = 2;
    localparam int AW  = 32;

    typedef struct packed {
        logic          mc_req;
        logic          mc_we;
        logic [AW-1:0] mc_addr;
        logic [31:0]   mc_wdata;
        logic          mc_agp;
        logic          h_err;
        logic          h_rvalid;
        logic [31:0]   h_rdata;
    } out_t;

    out_t s_d, s_q;

    logic          stack;
    logic [1:0]    order;
    logic [31:0]   memsize;
    logic [31:0]   agp_off;
    logic [AW-1:0] dec_addr [NAP];
    logic [NAP-1:0] dec_err;
    logic [NAP-1:0] dec_agp;
    logic [31:0]   wdata_sw;
    logic [31:0]   rdata_sw;

    aper_cfg #(
        .APER_SIZE(APER_SIZE), .MEM_RST(MEM_RST),
        .AGP_RST(AGP_RST), .REG_WIN(REG_WIN)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .rd(cfg_rd), .wr(cfg_wr),
        .addr(cfg_addr), .be(cfg_be), .wdata(cfg_wdata),
        .bar_ap0(bar_ap0), .bar_ap1(bar_ap1), .bar_reg(bar_reg),
        .rvalid(cfg_rvalid), .rdata(cfg_rdata),
        .stack(stack), .order(order), .memsize(memsize), .agp_off(agp_off)
    );

    for (genvar a = 0; a < NAP; a++) begin : g_ap
        aper_decode #(.IDX(a), .AW(AW), .APER_SIZE(APER_SIZE)) u_dec (
            .off(h_off), .fb_start(fb_start), .stack(stack),
            .memsize(memsize), .agp_off(agp_off),
            .addr(dec_addr[a]), .err(dec_err[a]), .agp(dec_agp[a])
        );
    end

    aper_swap #(.LANES(4)) u_wswap (
        .din(h_wdata), .en(order[h_sel]), .dout(wdata_sw)
    );
    aper_swap #(.LANES(4)) u_rswap (
        .din(mc_rdata), .en(order[mc_rsel]), .dout(rdata_sw)
    );

    always_comb begin
        s_d          = s_q;
        s_d.mc_req   = h_req && !dec_err[h_sel];
        s_d.h_err    = h_req && dec_err[h_sel];
        s_d.mc_we    = h_req && !dec_err[h_sel] && h_we;
        s_d.mc_agp   = h_req && dec_agp[h_sel];
        if (h_req && !dec_err[h_sel]) begin
            s_d.mc_addr  = dec_addr[h_sel];
            s_d.mc_wdata = wdata_sw;
        end
        s_d.h_rvalid = mc_rvalid;
        if (mc_rvalid) s_d.h_rdata = rdata_sw;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mc_req   = s_q.mc_req;
    assign mc_we    = s_q.mc_we;
    assign mc_addr  = s_q.mc_addr;
    assign mc_wdata = s_q.mc_wdata;
    assign mc_agp   = s_q.mc_agp;
    assign h_err    = s_q.h_err;
    assign h_rvalid = s_q.h_rvalid;
    assign h_rdata  = s_q.h_rdata;
endmodule

// File: rtl/aper_xlate_chk.sv
module aper_xlate_chk (
    input logic clk,
    input logic rst_n,
    input logic h_req,
    input logic mc_req,
    input logic mc_agp,
    input logic h_err,
    input logic mc_rvalid,
    input logic h_rvalid,
    input logic cfg_rd,
    input logic cfg_rvalid
);
    // R5: a refused access never reaches the memory controller
    a_r5_err_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
        h_err |-> !mc_req);

    // R12: every host strobe yields exactly one of request or error
    a_r12_req_answered: assert property (@(posedge clk) disable iff (!rst_n)
        h_req |=> (mc_req ^ h_err));

    // R12: no strobe, no response
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !h_req |=> (!mc_req && !h_err));

    // R4: the port image tag only travels with a forwarded request
    a_r4_agp_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        mc_agp |-> mc_req);

    // R7: read data is returned one cycle after it arrives
    a_r7_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        mc_rvalid |=> h_rvalid);

    // R1: register reads answer in the following cycle
    a_r1_cfg_latency: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd |=> cfg_rvalid);
endmodule

bind aper_xlate aper_xlate_chk u_chk (
    .clk(clk), .rst_n(rst_n), .h_req(h_req), .mc_req(mc_req),
    .mc_agp(mc_agp), .h_err(h_err), .mc_rvalid(mc_rvalid),
    .h_rvalid(h_rvalid), .cfg_rd(cfg_rd), .cfg_rvalid(cfg_rvalid)
);

// File: tb/sim_aper_xlate.sv
`timescale 1ns/1ps
module sim_aper_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fb_start = 32'h4000_0000;
    logic [31:0] bar_ap0  = 32'hE000_0008;
    logic [31:0] bar_ap1  = 32'hE400_000C;
    logic [31:0] bar_reg  = 32'hF000_0007;
    logic        h_req = 0, h_sel = 0, h_we = 0;
    logic [31:0] h_off = 0, h_wdata = 0;
    logic        mc_req, mc_we, mc_agp, h_err;
    logic [31:0] mc_addr, mc_wdata;
    logic        mc_rvalid = 0, mc_rsel = 0;
    logic [31:0] mc_rdata = 0;
    logic        h_rvalid;
    logic [31:0] h_rdata;
    logic        cfg_rd = 0, cfg_wr = 0;
    logic [11:0] cfg_addr = 0;
    logic [3:0]  cfg_be = 0;
    logic [31:0] cfg_wdata = 0;
    logic        cfg_rvalid;
    logic [31:0] cfg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    aper_xlate u0 (.*);

    // {sel, off, exp_err, exp_agp, exp_addr}
    localparam int NV = 8;
    localparam logic [66:0] VEC [NV] = '{
        {1'b0, 32'h0000_0010, 1'b0, 1'b0, 32'h4000_0010},
        {1'b1, 32'h0000_0010, 1'b0, 1'b0, 32'h4000_0010},
        {1'b0, 32'h00FF_FFFC, 1'b0, 1'b0, 32'h40FF_FFFC},
        {1'b1, 32'h0100_0000, 1'b1, 1'b0, 32'h0},
        {1'b0, 32'h017F_FFFC, 1'b1, 1'b0, 32'h0},
        {1'b0, 32'h0180_0000, 1'b0, 1'b1, 32'h4180_0000},
        {1'b1, 32'h01FF_FFFC, 1'b0, 1'b1, 32'h41FF_FFFC},
        {1'b0, 32'h0200_0000, 1'b1, 1'b0, 32'h0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host(input logic sel, input logic we, input logic [31:0] off,
                        input logic [31:0] wd);
        @(negedge clk);
        h_req = 1; h_sel = sel; h_we = we; h_off = off; h_wdata = wd;
        @(posedge clk); #1;
        h_req = 0; h_we = 0;
    endtask

    task automatic cwr(input logic [11:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_wr = 0;
    endtask

    task automatic crd(input logic [11:0] a, input logic [3:0] be, output logic [31:0] d);
        @(negedge clk);
        cfg_rd = 1; cfg_addr = a; cfg_be = be;
        @(posedge clk); #1;
        cfg_rd = 0;
        d = cfg_rvalid ? cfg_rdata : 32'hDEAD_BEEF;
    endtask

    task automatic rret(input logic sel, input logic [31:0] d);
        @(negedge clk);
        mc_rvalid = 1; mc_rsel = sel; mc_rdata = d;
        @(posedge clk); #1;
        mc_rvalid = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(posedge clk);
        #1;
        // R12: outputs quiet in reset
        chk("R12 reset mc_req", {31'b0, mc_req}, 32'h0);
        chk("R12 reset h_err", {31'b0, h_err}, 32'h0);
        @(negedge clk); rst_n = 1;

        // R1 reset values
        crd(12'h108, 4'hF, r); chk("R1 window size", r, 32'h0200_0000);
        crd(12'h130, 4'hF, r); chk("R1 path ctl", r, 32'h0);
        crd(12'h0F8, 4'hF, r); chk("R1 memsize", r, 32'h0100_0000);
        crd(12'h118, 4'hF, r); chk("R1 agp offset", r, 32'h0180_0000);
        crd(12'h11C, 4'hF, r); chk("R1 byte order", r, 32'h0);

        // R8 bases and register window
        crd(12'h100, 4'hF, r); chk("R8 base0", r, 32'hE000_0000);
        crd(12'h104, 4'hF, r); chk("R8 base1", r, 32'hE400_0000);
        crd(12'h10C, 4'hF, r); chk("R8 reg base", r, 32'hF000_0000);
        crd(12'h110, 4'hF, r); chk("R8 reg size", r, 32'h0000_4000);

        // R2 R4 R5 vector table, mirrored mode
        for (int i = 0; i < NV; i++) begin
            host(VEC[i][66], 1'b0, VEC[i][65:34], 32'h0);
            chk("R5 err flag", {31'b0, h_err}, {31'b0, VEC[i][33]});
            chk("R5 req gating", {31'b0, mc_req}, {31'b0, ~VEC[i][33]});
            chk("R4 agp flag", {31'b0, mc_agp}, {31'b0, VEC[i][32]});
            if (!VEC[i][33]) chk("R2 mirrored addr", mc_addr, VEC[i][31:0]);
        end
        @(posedge clk); #1;
        chk("R12 idle after access", {30'b0, mc_req, h_err}, 32'h0);

        // R9 byte lanes on read
        crd(12'h108, 4'b1000, r); chk("R9 lane3 read", r, 32'h0200_0000);
        crd(12'h108, 4'b0001, r); chk("R9 lane0 read", r, 32'h0);

        // R10 read-only ignore writes
        cwr(12'h108, 4'hF, 32'hFFFF_FFFF);
        crd(12'h108, 4'hF, r); chk("R10 size ro", r, 32'h0200_0000);
        cwr(12'h100, 4'hF, 32'h1234_5670);
        crd(12'h100, 4'hF, r); chk("R10 base0 ro", r, 32'hE000_0000);

        // R9 lane-gated write: lane 0 does not reach bit 23
        cwr(12'h130, 4'b0001, 32'hFFFF_FFFF);
        crd(12'h130, 4'hF, r); chk("R9 path lane0 write", r, 32'h0);
        // R10 only bit 23 sticks
        cwr(12'h130, 4'b0100, 32'hFFFF_FFFF);
        crd(12'h130, 4'hF, r); chk("R10 path reserved", r, 32'h0080_0000);

        // R3 stacked mode
        host(1'b1, 1'b0, 32'h10, 32'h0);
        chk("R3 stacked ap1", mc_addr, 32'h4200_0010);
        host(1'b0, 1'b0, 32'h10, 32'h0);
        chk("R3 stacked ap0", mc_addr, 32'h4000_0010);

        // R11 same-cycle mode change: old mode applies
        @(negedge clk);
        cfg_wr = 1; cfg_addr = 12'h130; cfg_be = 4'hF; cfg_wdata = 32'h0;
        h_req = 1; h_sel = 1; h_off = 32'h20;
        @(posedge clk); #1;
        cfg_wr = 0; h_req = 0;
        chk("R11 old mode used", mc_addr, 32'h4200_0020);
        host(1'b1, 1'b0, 32'h20, 32'h0);
        chk("R11 new mode after", mc_addr, 32'h4000_0020);

        // R6 per-window byte order
        cwr(12'h11C, 4'hF, 32'h2);
        host(1'b1, 1'b1, 32'h40, 32'h1122_3344);
        chk("R6 ap1 swapped", mc_wdata, 32'h4433_2211);
        chk("R6 write flag", {31'b0, mc_we}, 32'h1);
        host(1'b0, 1'b1, 32'h40, 32'h1122_3344);
        chk("R6 ap0 straight", mc_wdata, 32'h1122_3344);

        // R11 same-cycle byte-order change
        @(negedge clk);
        cfg_wr = 1; cfg_addr = 12'h11C; cfg_be = 4'hF; cfg_wdata = 32'h1;
        h_req = 1; h_sel = 0; h_we = 1; h_off = 32'h44; h_wdata = 32'hA1B2_C3D4;
        @(posedge clk); #1;
        cfg_wr = 0; h_req = 0; h_we = 0;
        chk("R11 old order used", mc_wdata, 32'hA1B2_C3D4);
        host(1'b0, 1'b1, 32'h44, 32'hA1B2_C3D4);
        chk("R6 ap0 swapped now", mc_wdata, 32'hD4C3_B2A1);

        // R7 read return
        rret(1'b0, 32'hAABB_CCDD);
        chk("R7 ap0 read swapped", h_rdata, 32'hDDCC_BBAA);
        chk("R7 rvalid", {31'b0, h_rvalid}, 32'h1);
        rret(1'b1, 32'hAABB_CCDD);
        chk("R7 ap1 read straight", h_rdata, 32'hAABB_CCDD);

        // R4 R5 moved boundaries
        cwr(12'h0F8, 4'hF, 32'h0080_0000);
        cwr(12'h118, 4'hF, 32'h0100_0000);
        host(1'b0, 1'b0, 32'h0080_0000, 32'h0);
        chk("R5 new gap", {31'b0, h_err}, 32'h1);
        host(1'b1, 1'b0, 32'h0100_0000, 32'h0);
        chk("R4 new agp start", {31'b0, mc_agp}, 32'h1);
        chk("R2 agp addr", mc_addr, 32'h4100_0000);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule